// File: doc/BRIEF.md
# Receiver Reset Sequencer with Configuration-Bit Workaround

This block runs the complete receive-side reset of one serial transceiver channel. After a start request it waits until the channel's PLL reports lock, raises the receiver reset, and while that reset is high reads one configuration word over the channel's dynamic reconfiguration port (DRP). It then writes the word back with a single bit cleared. Once that write is acknowledged it drops the reset, again qualified by lock. It then watches the PMA-reset-done status for a falling edge and writes the saved word back, so the bit returns to its original value while PMA-reset-done is still low. Completion is reported when the receiver reset-done status goes high.

Every wait is bounded by a programmable cycle limit. Running out of cycles, or seeing PMA-reset-done return high before the restore write is acknowledged, ends the run in an error state. A simulation speed-up option skips all DRP traffic and issues a plain reset pulse of fixed length. The per-stage receive resets and the reset-mode select are tied low for the whole sequence, which keeps the transceiver in sequential reset mode.

Top module: `rxrst_seq`

## Requirements
- R1: After reset, rxRstOut, drpEn, drpWe, seqDone and seqErr are all 0.
- R2: After startReq, rxRstOut rises only in the cycle after pllLocked is seen high. Release of rxRstOut likewise needs pllLocked high.
- R3: Every DRP access is a drpEn pulse one cycle long, always at address 9'h011. drpWe is 1 only for writes. The first access is a read, and the second is a write of the read word with bit 11 forced to 0 and all other bits unchanged.
- R4: rxRstOut stays high at least until drpRdy acknowledges the bit-clearing write, and it is never released before that write completes.
- R5: After the release, the block waits for a 1-to-0 transition of pmaDoneIn before it issues the restore write.
- R6: The restore write carries the complete word captured by the read, so bit 11 regains its original value, and it is acknowledged while pmaDoneIn is still low.
- R7: If pmaDoneIn is seen high while the restore write is still unacknowledged, the block enters the error state (seqErr = 1).
- R8: seqDone rises only after rxDoneIn is seen high. It stays high until the next startReq, and it is never high together with seqErr.
- R9: stageRstOut (5 bits) and modeSelOut are 0 at all times.
- R10: Any wait that lasts TMO_CYC cycles without its awaited event ends in the error state with rxRstOut low. A later startReq restarts the sequence from the lock wait.
- R11: With SIM_FAST = 1, no DRP access occurs. rxRstOut is high for exactly PULSE_CYC cycles when lock is present, and seqDone follows rxDoneIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Starts a reset sequence from idle, done or error |
| pllLocked | input | 1 | Lock status of the associated PLL |
| pmaDoneIn | input | 1 | PMA-reset-done status from the channel |
| rxDoneIn | input | 1 | Receiver reset-done status from the channel |
| drpRdy | input | 1 | DRP access acknowledge |
| drpDin | input | 16 | DRP read data, valid with drpRdy |
| rxRstOut | output | 1 | Receiver reset, driven from a flip-flop |
| stageRstOut | output | 5 | Per-stage receive resets, held low |
| modeSelOut | output | 1 | Reset-mode select, held low (sequential mode) |
| drpEn | output | 1 | DRP access strobe |
| drpWe | output | 1 | DRP write qualifier |
| drpAddr | output | 9 | DRP address |
| drpDout | output | 16 | DRP write data |
| seqDone | output | 1 | Sequence completed |
| seqErr | output | 1 | Sequence aborted by timeout or a missed restore window |

## Verification
The bench builds two instances. The first uses SIM_FAST = 0, TMO_CYC = 64 and a channel model whose DRP latency and PMA-low window the bench can set. This makes both the timeout abort and a restore write that overruns a deliberately short PMA-low window reachable in a few hundred cycles. The second uses SIM_FAST = 1 and PULSE_CYC = 6, so the length of the bypass pulse and the absence of DRP traffic are measured directly. Configuration words with bit 11 set and with bit 11 clear show that the restore puts back the original value rather than a fixed one.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_LOCK, ST_ASSERT_RST, ST_DRP_READ, ST_DRP_WR_CLR,
    ST_RELEASE, ST_WAIT_PMA_FALL, ST_DRP_WR_RST, ST_WAIT_RXDONE,
    ST_DONE, ST_ERR
  } seqState_e;

  typedef struct packed {
    logic goRd;     // issue DRP read
    logic goWrClr;  // capture read word, issue write with bit cleared
    logic goWrRst;  // issue write of captured word
    logic cntClr;   // restart wait counter
  } ctrlStb_t;

endpackage

// File: rtl/rxrst_dpath.sv
module rxrst_dpath import rxrst_pkg::*; #(
  parameter int AW        = 9,
  parameter int DW        = 16,
  parameter logic [AW-1:0] TGT_ADDR = 9'h011,
  parameter int TGT_BIT   = 11,
  parameter int TMO_CYC   = 1000,
  parameter int PULSE_CYC = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStb_t      stb,
  input  logic [DW-1:0] drpDin,
  input  logic          pmaDoneIn,
  output logic          drpEn,
  output logic          drpWe,
  output logic [AW-1:0] drpAddr,
  output logic [DW-1:0] drpDout,
  output logic          pmaFell,
  output logic          tmoHit,
  output logic          pulseHit
);
  localparam int CNT_MAX = (TMO_CYC > PULSE_CYC) ? TMO_CYC : PULSE_CYC;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [DW-1:0] CLR_MASK = ~(DW'(1) << TGT_BIT);

  logic [DW-1:0] savedWord;
  logic [CW-1:0] waitCnt;
  logic          pmaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drpEn     <= 1'b0;
      drpWe     <= 1'b0;
      drpDout   <= '0;
      savedWord <= '0;
      pmaPrev   <= 1'b0;
      waitCnt   <= '0;
    end else begin
      drpEn   <= stb.goRd | stb.goWrClr | stb.goWrRst;
      drpWe   <= stb.goWrClr | stb.goWrRst;
      pmaPrev <= pmaDoneIn;
      if (stb.goWrClr) begin
        savedWord <= drpDin;
        drpDout   <= drpDin & CLR_MASK;
      end else if (stb.goWrRst) begin
        drpDout <= savedWord;
      end
      if (stb.cntClr)
        waitCnt <= '0;
      else if (waitCnt != CW'(CNT_MAX))
        waitCnt <= waitCnt + 1'b1;
    end
  end

  assign drpAddr  = TGT_ADDR;
  assign pmaFell  = pmaPrev & ~pmaDoneIn;
  assign tmoHit   = (waitCnt >= CW'(TMO_CYC - 1));
  assign pulseHit = (waitCnt >= CW'(PULSE_CYC - 1));
endmodule

// File: rtl/rxrst_ctrl.sv
module rxrst_ctrl import rxrst_pkg::*; #(
  parameter bit SIM_FAST = 1'b0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     pllLocked,
  input  logic     pmaDoneIn,
  input  logic     rxDoneIn,
  input  logic     drpRdy,
  input  logic     pmaFell,
  input  logic     tmoHit,
  input  logic     pulseHit,
  output ctrlStb_t stb,
  output logic     rxRstOut,
  output logic     seqDone,
  output logic     seqErr
);
  seqState_e state, nxt;
  logic      rstNext;

  always_comb begin
    nxt     = state;
    stb     = '0;
    rstNext = rxRstOut;
    case (state)
      ST_IDLE, ST_DONE, ST_ERR:
        if (startReq) nxt = ST_WAIT_LOCK;
      ST_WAIT_LOCK:
        if (pllLocked) begin
          nxt = ST_ASSERT_RST;
          rstNext = 1'b1;
        end else if (tmoHit) nxt = ST_ERR;
      ST_ASSERT_RST:
        if (SIM_FAST) begin
          if (pulseHit && pllLocked) begin
            rstNext = 1'b0;
            nxt = ST_WAIT_RXDONE;
          end else if (tmoHit) nxt = ST_ERR;
        end else begin
          stb.goRd = 1'b1;
          nxt = ST_DRP_READ;
        end
      ST_DRP_READ:
        if (drpRdy) begin
          stb.goWrClr = 1'b1;
          nxt = ST_DRP_WR_CLR;
        end else if (tmoHit) nxt = ST_ERR;
      ST_DRP_WR_CLR:
        if (drpRdy) nxt = ST_RELEASE;
        else if (tmoHit) nxt = ST_ERR;
      ST_RELEASE:
        if (pllLocked) begin
          rstNext = 1'b0;
          nxt = ST_WAIT_PMA_FALL;
        end else if (tmoHit) nxt = ST_ERR;
      ST_WAIT_PMA_FALL:
        if (pmaFell) begin
          stb.goWrRst = 1'b1;
          nxt = ST_DRP_WR_RST;
        end else if (tmoHit) nxt = ST_ERR;
      ST_DRP_WR_RST:
        if (drpRdy) nxt = ST_WAIT_RXDONE;
        else if (pmaDoneIn || tmoHit) nxt = ST_ERR;
      ST_WAIT_RXDONE:
        if (rxDoneIn) nxt = ST_DONE;
        else if (tmoHit) nxt = ST_ERR;
      default: nxt = ST_IDLE;
    endcase
    if (nxt == ST_ERR) rstNext = 1'b0;
    stb.cntClr = (nxt != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rxRstOut <= 1'b0;
    end else begin
      state    <= nxt;
      rxRstOut <= rstNext;
    end
  end

  assign seqDone = (state == ST_DONE);
  assign seqErr  = (state == ST_ERR);
endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq import rxrst_pkg::*; #(
  parameter int AW        = 9,
  parameter int DW        = 16,
  parameter int NSTAGE    = 5,
  parameter logic [AW-1:0] TGT_ADDR = 9'h011,
  parameter int TGT_BIT   = 11,
  parameter int TMO_CYC   = 1000,
  parameter int PULSE_CYC = 8,
  parameter bit SIM_FAST  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              pllLocked,
  input  logic              pmaDoneIn,
  input  logic              rxDoneIn,
  input  logic              drpRdy,
  input  logic [DW-1:0]     drpDin,
  output logic              rxRstOut,
  output logic [NSTAGE-1:0] stageRstOut,
  output logic              modeSelOut,
  output logic              drpEn,
  output logic              drpWe,
  output logic [AW-1:0]     drpAddr,
  output logic [DW-1:0]     drpDout,
  output logic              seqDone,
  output logic              seqErr
);
  ctrlStb_t stb;
  logic pmaFell, tmoHit, pulseHit;

  rxrst_ctrl #(.SIM_FAST(SIM_FAST)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pllLocked(pllLocked),
    .pmaDoneIn(pmaDoneIn), .rxDoneIn(rxDoneIn), .drpRdy(drpRdy),
    .pmaFell(pmaFell), .tmoHit(tmoHit), .pulseHit(pulseHit), .stb(stb),
    .rxRstOut(rxRstOut), .seqDone(seqDone), .seqErr(seqErr)
  );

  rxrst_dpath #(
    .AW(AW), .DW(DW), .TGT_ADDR(TGT_ADDR), .TGT_BIT(TGT_BIT),
    .TMO_CYC(TMO_CYC), .PULSE_CYC(PULSE_CYC)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .drpDin(drpDin), .pmaDoneIn(pmaDoneIn),
    .drpEn(drpEn), .drpWe(drpWe), .drpAddr(drpAddr), .drpDout(drpDout),
    .pmaFell(pmaFell), .tmoHit(tmoHit), .pulseHit(pulseHit)
  );

  assign stageRstOut = '0;
  assign modeSelOut  = 1'b0;
endmodule

// File: rtl/rxrst_chk.sv
module rxrst_chk #(
  parameter int AW     = 9,
  parameter int DW     = 16,
  parameter int NSTAGE = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              pllLocked,
  input logic              pmaDoneIn,
  input logic              rxDoneIn,
  input logic              drpRdy,
  input logic [DW-1:0]     drpDin,
  input logic              rxRstOut,
  input logic [NSTAGE-1:0] stageRstOut,
  input logic              modeSelOut,
  input logic              drpEn,
  input logic              drpWe,
  input logic [AW-1:0]     drpAddr,
  input logic [DW-1:0]     drpDout,
  input logic              seqDone,
  input logic              seqErr
);
  // A write issued while the receiver reset is high and not yet acknowledged
  logic clrPending;
  always_ff @(posedge clk) begin
    if (!rstN) clrPending <= 1'b0;
    else if (drpEn && drpWe && rxRstOut) clrPending <= 1'b1;
    else if (drpRdy) clrPending <= 1'b0;
  end

  a_r3_en_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    drpEn |=> !drpEn);

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (rxRstOut && clrPending) |=> rxRstOut);

  a_r2_rise_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxRstOut) |-> $past(pllLocked));

  a_r8_done_after_rxdone: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> $past(rxDoneIn));

  a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(seqDone && seqErr));

  a_r10_err_reset_low: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> !rxRstOut);
endmodule

bind rxrst_seq rxrst_chk #(.AW(AW), .DW(DW), .NSTAGE(NSTAGE)) chk_i (.*);

// File: tb/rxrst_seq_tb_top.sv
module rxrst_seq_tb_top;
  localparam int TMO = 64;
  localparam int PULSE = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // main instance signals
  logic startReq = 0, pllLocked = 1, pmaDone = 1, rxDone = 0, drpRdy = 0;
  logic [15:0] drpDin = '0;
  logic rxRst, modeSel, drpEn, drpWe, seqDone, seqErr;
  logic [4:0] stageRst;
  logic [8:0] drpAddr;
  logic [15:0] drpDout;

  // fast instance signals
  logic fStart = 0, fRxDone = 0;
  logic fRst, fModeSel, fEn, fWe, fDone, fErr;
  logic [4:0] fStage;
  logic [8:0] fAddr;
  logic [15:0] fDout;

  rxrst_seq #(.TMO_CYC(TMO), .PULSE_CYC(PULSE), .SIM_FAST(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pllLocked(pllLocked),
    .pmaDoneIn(pmaDone), .rxDoneIn(rxDone), .drpRdy(drpRdy), .drpDin(drpDin),
    .rxRstOut(rxRst), .stageRstOut(stageRst), .modeSelOut(modeSel),
    .drpEn(drpEn), .drpWe(drpWe), .drpAddr(drpAddr), .drpDout(drpDout),
    .seqDone(seqDone), .seqErr(seqErr));

  rxrst_seq #(.TMO_CYC(TMO), .PULSE_CYC(PULSE), .SIM_FAST(1'b1)) dut_fast_i (
    .clk(clk), .rstN(rstN), .startReq(fStart), .pllLocked(pllLocked),
    .pmaDoneIn(1'b1), .rxDoneIn(fRxDone), .drpRdy(1'b0), .drpDin(16'h0),
    .rxRstOut(fRst), .stageRstOut(fStage), .modeSelOut(fModeSel),
    .drpEn(fEn), .drpWe(fWe), .drpAddr(fAddr), .drpDout(fDout),
    .seqDone(fDone), .seqErr(fErr));

  int nVec = 0, nBad = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // channel model state
  logic [15:0] cfgWord = '0;
  int  lat = 4, lowCyc = 30;
  bit  mute = 0;
  bit  pend = 0, pendWe = 0;
  int  pendCnt = 0;
  logic [15:0] pendData = '0;
  int  rdCount = 0, wrCount = 0, drpCount = 0;
  logic [15:0] wrVal [2];
  bit  wrRstHigh [2];
  bit  wrPmaLow [2];
  bit  earlyFall = 0, riseNoLock = 0;
  bit  prevRst = 0, pmaRun = 0;
  int  pmaT = 0;
  bit  fPrev = 0;
  int  fLen = 0, fLastLen = 0, fT = 0, fDrp = 0;
  bit  fRun = 0;

  // behavioural channel and per-cycle reference checks, on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      // R9: tied-low outputs on both instances
      chk(stageRst == 5'd0 && modeSel == 1'b0, "R9", {stageRst, modeSel}, 0);
      chk(fStage == 5'd0 && fModeSel == 1'b0, "R9 fast", {fStage, fModeSel}, 0);
      if (drpEn) chk(drpAddr == 9'h011, "R3 addr", drpAddr, 9'h011);
      // status model
      if (rxRst && !prevRst) begin
        rxDone = 1'b0;
        if (!pllLocked) riseNoLock = 1;
      end
      if (!rxRst && prevRst) begin
        if (wrCount == 0) earlyFall = 1;
        pmaRun = 1; pmaT = 0;
      end
      if (pmaRun) begin
        pmaT++;
        if (pmaT == 3) pmaDone = 1'b0;
        if (pmaT == 3 + lowCyc) pmaDone = 1'b1;
        if (pmaT == 8 + lowCyc) begin rxDone = 1'b1; pmaRun = 0; end
      end
      prevRst = rxRst;
      // DRP model
      drpRdy = 1'b0;
      if (pend) begin
        pendCnt--;
        if (pendCnt == 0) begin
          pend = 0;
          drpRdy = 1'b1;
          if (pendWe) begin
            cfgWord = pendData;
            if (wrCount < 2) begin
              wrVal[wrCount] = pendData;
              wrRstHigh[wrCount] = rxRst;
              wrPmaLow[wrCount] = !pmaDone;
            end
            wrCount++;
          end else begin
            drpDin = cfgWord;
            rdCount++;
          end
        end
      end
      if (drpEn) begin
        drpCount++;
        if (!mute) begin
          pend = 1; pendCnt = lat; pendWe = drpWe; pendData = drpDout;
        end
      end
      // fast instance model
      if (fEn) fDrp++;
      if (fRst) begin
        if (!fPrev) fRxDone = 1'b0;
        fLen++;
      end
      if (!fRst && fPrev) begin fLastLen = fLen; fLen = 0; fRun = 1; fT = 0; end
      if (fRun) begin fT++; if (fT == 4) begin fRxDone = 1'b1; fRun = 0; end end
      fPrev = fRst;
    end
    if (cycles > 100000) begin
      chk(0, "watchdog", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic clearLog();
    rdCount = 0; wrCount = 0; drpCount = 0; earlyFall = 0; riseNoLock = 0;
    wrVal[0] = '0; wrVal[1] = '0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (seqDone || seqErr) break;
    end
  endtask

  task automatic goodRun(input logic [15:0] w, input string tag);
    clearLog(); cfgWord = w; lat = 4; lowCyc = 30; mute = 0;
    pulseStart(); waitEnd();
    chk(seqDone && !seqErr, {tag, " R8 done"}, {seqDone, seqErr}, 2'b10);
    chk(rdCount == 1, {tag, " R3 one read"}, rdCount, 1);
    chk(wrVal[0] == (w & ~16'h0800), {tag, " R3 clear word"}, wrVal[0], w & ~16'h0800);
    chk(wrRstHigh[0], {tag, " R4 reset high at clear ack"}, wrRstHigh[0], 1);
    chk(!earlyFall, {tag, " R4 no early release"}, earlyFall, 0);
    chk(!riseNoLock, {tag, " R2 lock before reset"}, riseNoLock, 0);
    chk(wrVal[1] == w, {tag, " R6 restore word"}, wrVal[1], w);
    chk(wrPmaLow[1], {tag, " R5 R6 restore inside low window"}, wrPmaLow[1], 1);
    chk(cfgWord == w, {tag, " R6 final word"}, cfgWord, w);
    chk(!rxRst, {tag, " R8 reset low at done"}, rxRst, 0);
    repeat (5) @(negedge clk);
    chk(seqDone, {tag, " R8 done held"}, seqDone, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state right after reset
    chk(!rxRst && !drpEn && !drpWe && !seqDone && !seqErr, "R1 reset state",
        {rxRst, drpEn, drpWe, seqDone, seqErr}, 0);
    chk(!fRst && !fDone && !fErr, "R1 reset state fast", {fRst, fDone, fErr}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rxRst && !seqDone && !seqErr, "R1 idle after reset", {rxRst, seqDone, seqErr}, 0);

    goodRun(16'hA9F5, "word with bit set");
    goodRun(16'h3456, "word with bit clear");

    // R2: hold off until lock
    clearLog(); cfgWord = 16'hFFFF; pllLocked = 1'b0;
    pulseStart();
    repeat (20) @(negedge clk);
    chk(!rxRst, "R2 no reset without lock", rxRst, 0);
    chk(drpCount == 0, "R2 no DRP without lock", drpCount, 0);
    pllLocked = 1'b1;
    waitEnd();
    chk(seqDone, "R2 completes after lock", seqDone, 1);
    chk(wrVal[0] == 16'hF7FF, "R3 all other bits kept", wrVal[0], 16'hF7FF);

    // R10: DRP never answers
    clearLog(); mute = 1;
    pulseStart(); waitEnd();
    chk(seqErr && !seqDone, "R10 timeout error", {seqErr, seqDone}, 2'b10);
    chk(!rxRst, "R10 reset dropped on error", rxRst, 0);
    mute = 0;
    repeat (10) @(negedge clk);

    // R7: low window shorter than restore latency
    clearLog(); cfgWord = 16'h0800; lat = 8; lowCyc = 2;
    pulseStart(); waitEnd();
    chk(seqErr, "R7 missed restore window", seqErr, 1);
    repeat (20) @(negedge clk);

    // R10: restart after error
    goodRun(16'h1234, "restart after error");

    // R11: bypass path
    @(negedge clk); fStart = 1'b1;
    @(negedge clk); fStart = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (fDone || fErr) break;
    end
    chk(fDone && !fErr, "R11 bypass done", {fDone, fErr}, 2'b10);
    chk(fLastLen == PULSE, "R11 pulse length", fLastLen, PULSE);
    chk(fDrp == 0, "R11 no DRP traffic", fDrp, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule